// File: doc/BRIEF.md
# VLAN tag hash filter

This block decides whether a VLAN-tagged frame passes a group filter. For each request it takes the frame's 16-bit tag control field, a 16-entry hash table, an enable for hash matching and a mode bit. The mode bit selects whether the hash covers the whole tag or only its 12-bit VLAN identifier. The block runs a reflected CRC-32 over the selected bits and folds the result into a 4-bit index. It then returns the table bit at that index as the accept decision.

A requester raises `valid_i` for one cycle with the tag, table, mode and enable. The decision appears a fixed number of cycles later with a one-cycle `done_o` pulse. A new request can be issued every cycle. When hash matching is disabled, every frame is accepted. The block does not find the tag in the frame stream and does not handle untagged frames.

Top module: `vtag_hash_filter`

## Requirements
- R1: While `rst_ni` is low and after it is released, `done_o` and `accept_o` are 0 until the first decision.
- R2: A request sampled on a rising edge with `valid_i`=1 produces exactly one `done_o` pulse one cycle long, visible after the third rising edge counting the sampling edge. Requests on consecutive cycles produce pulses on consecutive cycles.
- R3: `tag_i`, `vid_only_i`, `hash_en_i` and `table_i` are sampled only on the edge where `valid_i` is 1. Changing them afterwards does not alter that request's decision.
- R4: The hash register starts at 32'hFFFFFFFF. For each data bit d, least significant bit first: f = reg[0] xor d, then reg = (reg >> 1) xor (f ? 32'hEDB88320 : 0). After the last bit the register is inverted. The 4-bit index is {reg[0], reg[1], reg[2], reg[3]}, so index bit 3 is reg[0].
- R5: With `vid_only_i`=1 the hash covers exactly `tag_i[11:0]` (12 bits). With `vid_only_i`=0 it covers all of `tag_i[15:0]` (16 bits).
- R6: With `hash_en_i`=1, `accept_o` equals `table_i[index]`, where table bit n corresponds to index value n. A table of all zeros rejects every tag and a table of all ones accepts every tag.
- R7: With `hash_en_i`=0, `accept_o` is 1 whatever the table holds.
- R8: `accept_o` keeps its value in every cycle where `done_o` is 0.
- R9: In 12-bit mode, tags that differ only in bits 15:12 (priority and drop-eligible bits) give the same decision. In 16-bit mode, some such pairs give different indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe, one cycle per tag |
| tag_i | input | 16 | Tag control field, identifier in bits 11:0 |
| vid_only_i | input | 1 | 1: hash the 12-bit identifier, 0: hash the full tag |
| hash_en_i | input | 1 | 1: consult the table, 0: accept all |
| table_i | input | 16 | Hash table, bit n is the accept bit for index n |
| done_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Decision, held until the next strobe |

## Verification
The bench sweeps every 12-bit identifier in identifier mode and a large set of full tags in 16-bit mode. It varies the priority bits throughout, so a design that hashed the priority bits in identifier mode, or dropped them in full mode, gives wrong indices. Each tag is queried under four tables, each of which isolates one index bit, so the exact index is recovered. Reversed index bit order, or a missing final inversion, shows up as a mismatch on almost every tag. Inputs are inverted right after sampling, and three requests are sent back to back. A design that read its inputs late, or lost a request in the pipeline, would change or drop decisions.

// File: rtl/vtag_hash_pkg.sv
package vtag_hash_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // one LSB-first serial step of the reflected CRC
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ ({CRC_W{fb}} & CRC_POLY_REFL);
  endfunction
endpackage

// File: rtl/vtag_crc_chain.sv
module vtag_crc_chain
  import vtag_hash_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 12
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              short_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = CRC_SEED;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign stage[gi+1] = crc_step(stage[gi], data_i[gi]);
  end

  // final complement on whichever length was requested
  assign crc_o = short_i ? ~stage[SHORT_W] : ~stage[DATA_W];
endmodule

// File: rtl/vtag_hash_index.sv
module vtag_hash_index
  import vtag_hash_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [CRC_W-1:0] crc_i,
  output logic [IDX_W-1:0] idx_o
);
  // top bits of the bit-reversed value: idx msb is crc lsb
  for (genvar gk = 0; gk < IDX_W; gk++) begin : g_rev
    assign idx_o[IDX_W-1-gk] = crc_i[gk];
  end

  logic unused_hi;
  assign unused_hi = ^crc_i[CRC_W-1:IDX_W];
endmodule

// File: rtl/vtag_table_pick.sv
module vtag_table_pick #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TBL_W = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TBL_W-1:0] tbl_i,
  output logic             hit_o
);
  logic [TBL_W-1:0] sel;

  for (genvar gi = 0; gi < TBL_W; gi++) begin : g_dec
    assign sel[gi] = (idx_i == IDX_W'(gi));
  end

  assign hit_o = |(sel & tbl_i);
endmodule

// File: rtl/vtag_hash_filter.sv
module vtag_hash_filter
  import vtag_hash_pkg::*;
#(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned VID_W = 12,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TBL_W = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             vid_only_i,
  input  logic             hash_en_i,
  input  logic [TBL_W-1:0] table_i,
  output logic             done_o,
  output logic             accept_o
);
  // stage 1: capture request
  logic             v1_q, short1_q, en1_q;
  logic [TAG_W-1:0] tag1_q;
  logic [TBL_W-1:0] tbl1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q     <= 1'b0;
      short1_q <= 1'b0;
      en1_q    <= 1'b0;
      tag1_q   <= '0;
      tbl1_q   <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        short1_q <= vid_only_i;
        en1_q    <= hash_en_i;
        tag1_q   <= tag_i;
        tbl1_q   <= table_i;
      end
    end
  end

  // hash
  logic [CRC_W-1:0] crc;
  logic [IDX_W-1:0] idx;

  vtag_crc_chain #(.DATA_W(TAG_W), .SHORT_W(VID_W)) u_crc (
    .data_i (tag1_q),
    .short_i(short1_q),
    .crc_o  (crc)
  );

  vtag_hash_index #(.IDX_W(IDX_W)) u_idx (
    .crc_i(crc),
    .idx_o(idx)
  );

  // stage 2: index register
  logic             v2_q, en2_q;
  logic [IDX_W-1:0] idx2_q;
  logic [TBL_W-1:0] tbl2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q   <= 1'b0;
      en2_q  <= 1'b0;
      idx2_q <= '0;
      tbl2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        en2_q  <= en1_q;
        idx2_q <= idx;
        tbl2_q <= tbl1_q;
      end
    end
  end

  // stage 3: lookup and decision
  logic hit;

  vtag_table_pick #(.IDX_W(IDX_W)) u_pick (
    .idx_i(idx2_q),
    .tbl_i(tbl2_q),
    .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      done_o <= v2_q;
      if (v2_q) accept_o <= en2_q ? hit : 1'b1;
    end
  end

  a_r2_done_after_three: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 done_o);

  a_r2_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i, 3));

  a_r7_disabled_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hash_en_i) |-> ##3 accept_o);

  a_r6_full_table_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hash_en_i && (&table_i)) |-> ##3 accept_o);

  a_r6_empty_table_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hash_en_i && (table_i == '0)) |-> ##3 !accept_o);

  a_r8_hold_between_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(accept_o));
endmodule

// File: tb/tb_vtag_hash_filter.sv
module tb_vtag_hash_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] tag_i = '0;
  logic        vid_only_i = 1'b0;
  logic        hash_en_i = 1'b0;
  logic [15:0] table_i = '0;
  logic        done_o, accept_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  vtag_hash_filter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .tag_i(tag_i),
    .vid_only_i(vid_only_i), .hash_en_i(hash_en_i), .table_i(table_i),
    .done_o(done_o), .accept_o(accept_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 195000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<195000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [3:0] model_idx(input logic [15:0] t, input logic vid_only);
    logic [31:0] r;
    int n;
    r = 32'hFFFFFFFF;
    n = vid_only ? 12 : 16;
    for (int i = 0; i < n; i++) begin
      logic f;
      f = r[0] ^ t[i];
      r = (r >> 1) ^ (f ? 32'hEDB88320 : 32'h0);
    end
    r = ~r;
    return {r[0], r[1], r[2], r[3]};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; inputs scrambled after the sampling edge (R3)
  task automatic query(input logic [15:0] t, input logic vo, input logic en,
                       input logic [15:0] tb, output logic d, output logic a);
    @(negedge clk_i);
    tag_i = t; vid_only_i = vo; hash_en_i = en; table_i = tb; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; tag_i = ~t; vid_only_i = ~vo; hash_en_i = ~en; table_i = ~tb;
    @(negedge clk_i);
    @(negedge clk_i);
    d = done_o; a = accept_o;
  endtask

  // recovers the index using four bit-isolating tables
  task automatic get_idx(input logic [15:0] t, input logic vo, output logic [3:0] idx,
                         output logic all_done);
    logic [15:0] masks [4];
    logic d, a;
    masks[0] = 16'hAAAA; masks[1] = 16'hCCCC; masks[2] = 16'hF0F0; masks[3] = 16'hFF00;
    all_done = 1'b1;
    for (int k = 0; k < 4; k++) begin
      query(t, vo, 1'b1, masks[k], d, a);
      idx[k] = a;
      all_done &= d;
    end
  endtask

  initial begin
    logic d, a, a0, dn;
    logic [3:0] got, exp;
    logic [15:0] t;
    logic [15:0] pa, pb;
    logic found;

    // R1: reset state
    #1;
    chk(done_o == 1'b0 && accept_o == 1'b0, "R1 during reset", {done_o, accept_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && accept_o == 1'b0, "R1 after release", {done_o, accept_o}, 0);

    // R6: empty and full tables
    query(16'h0123, 1'b0, 1'b1, 16'h0000, d, a);
    chk(d && !a, "R6 empty table rejects", {d, a}, 2);
    query(16'hE456, 1'b1, 1'b1, 16'hFFFF, d, a);
    chk(d && a, "R6 full table accepts", {d, a}, 3);

    // R8: hold with no done
    @(negedge clk_i);
    chk(!done_o && accept_o, "R8 hold cycle 1", {done_o, accept_o}, 1);
    @(negedge clk_i);
    chk(!done_o && accept_o, "R8 hold cycle 2", {done_o, accept_o}, 1);

    // R7: disabled accepts with empty table
    for (int i = 0; i < 4; i++) begin
      query(16'(i * 16'h1357), i[0], 1'b0, 16'h0000, d, a);
      chk(d && a, "R7 disabled accepts", {d, a}, 3);
    end

    // R3: decision uses sampled inputs (table single bit at expected index)
    exp = model_idx(16'h5A5A, 1'b0);
    query(16'h5A5A, 1'b0, 1'b1, 16'(1) << exp, d, a);
    chk(d && a, "R3 sampled inputs used", {d, a}, 3);

    // R2: back-to-back requests
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      tag_i = 16'(16'h0100 * i + 7); vid_only_i = 1'b1; hash_en_i = 1'b1;
      table_i = 16'(1) << model_idx(16'(16'h0100 * i + 7), 1'b1);
      if (i == 1) table_i = ~table_i;
      valid_i = 1'b1;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    chk(done_o && accept_o, "R2 burst first", {done_o, accept_o}, 3);
    @(negedge clk_i);
    chk(done_o && !accept_o, "R2 burst second", {done_o, accept_o}, 2);
    @(negedge clk_i);
    chk(done_o && accept_o, "R2 burst third", {done_o, accept_o}, 3);
    @(negedge clk_i);
    chk(!done_o, "R2 single pulse per request", done_o, 0);

    // R4 R5 R9: full sweep of identifiers in 12-bit mode, priority bits varied
    for (int v = 0; v < 4096; v++) begin
      t = {v[2:0] ^ 3'b101, v[5], v[11:0]};
      get_idx(t, 1'b1, got, dn);
      exp = model_idx({4'h0, v[11:0]}, 1'b1);
      chk(dn, "R2 done in 12-bit sweep", dn, 1);
      chk(got == exp, "R4 R5 R9 index 12-bit mode", got, exp);
    end

    // R4 R5: full-tag mode, 256 identifiers times every priority value
    for (int v = 0; v < 256; v++) begin
      for (int p = 0; p < 8; p++) begin
        t = {p[2:0], v[0], 12'((v * 37 + 11) % 4096)};
        get_idx(t, 1'b0, got, dn);
        exp = model_idx(t, 1'b0);
        chk(dn, "R2 done in 16-bit sweep", dn, 1);
        chk(got == exp, "R4 R5 index 16-bit mode", got, exp);
      end
    end

    // R9: a pair differing only in priority splits in 16-bit mode, joins in 12-bit mode
    found = 1'b0; pa = '0; pb = '0;
    for (int p = 1; p < 8 && !found; p++) begin
      if (model_idx({3'd0, 1'b0, 12'h064}, 1'b0) != model_idx({p[2:0], 1'b0, 12'h064}, 1'b0)) begin
        found = 1'b1; pa = {3'd0, 13'h0064}; pb = {p[2:0], 13'h0064};
      end
    end
    chk(found, "R9 model pair exists", found, 1);
    query(pa, 1'b0, 1'b1, 16'(1) << model_idx(pa, 1'b0), d, a0);
    query(pb, 1'b0, 1'b1, 16'(1) << model_idx(pa, 1'b0), d, a);
    chk(a0 && !a, "R9 priority splits 16-bit mode", {a0, a}, 2);
    query(pb, 1'b1, 1'b1, 16'(1) << model_idx(pa, 1'b1), d, a);
    chk(a, "R9 priority ignored 12-bit mode", a, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule